// File: doc/BRIEF.md
# Sampled-line I2C EEPROM slave

This block is a small read-only style EEPROM slave that watches an I2C bus through discrete samples instead of a free-running clock on the bus wires. A host presents one (SCL, SDA) pair per strobe, and the slave compares it with the levels it stored from the previous strobe to find START, STOP and SCL rising edges. A transfer is one START, an 8-bit control byte sent most significant bit first, an acknowledge clock, an 8-bit word address, and a second acknowledge clock. After that the slave goes back to idle.

When the last control bit is 1, the address clocks also return the data byte latched at the end of the previous access, most significant bit first. The byte named by the new address is latched at the end of the address phase, and it is returned by the next read. The host sees the bus through a readback pin that shows the last stored SDA level, including every level the slave forced. The contents array is filled through a separate write port.

Both inputs are strobe-only streams: a sample or a preload word is taken in the cycle its valid is high. There is no ready and no back-pressure, so every offered item is consumed at once. With no strobe, nothing changes.

Top module: `i2c_sample_eeprom`

## Requirements
- R1: After reset the stored SCL and SDA levels are 1, so `sda_o` reads 1, and the slave is idle with its latched data byte at 0.
- R2: A sample with SCL high in both the stored and the new level, and SDA going from 1 to 0, is a START. It restarts the bit count and clears the control byte.
- R3: While idle (no transfer in progress and no acknowledge pending), every sample other than a START is ignored, apart from storing its levels.
- R4: After eight accepted control bits, the next SCL rising edge has SDA forced to 0 (acknowledge), and `sda_o` reads 0 after that sample.
- R5: When bit 0 of the control byte (the last bit sent) is 1, each of the eight address rising edges stores the next bit of the previously latched byte, MSB first, as the SDA level.
- R6: After the eighth address bit the slave latches contents[address] and forces SDA to 0 on the next SCL rising edge. Then it returns to idle.
- R7: When bit 0 of the control byte is 0, the stored SDA level during the address bits follows the host.
- R8: An SCL rising edge on which SDA also changes is ignored as a bit: it does not advance the count.
- R9: A STOP (SDA going from 0 to 1 with SCL high in both samples) changes only the stored levels. A transfer in progress continues.
- R10: A preload write places its data at its address in the contents array. Later reads of that address return the new byte.
- R11: A START in the middle of a transfer discards the bits already collected, and the control byte is counted again from its first bit.
- R12: Input levels presented without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe; the pair below is taken in this cycle |
| smp_scl | input | 1 | Sampled SCL level |
| smp_sda | input | 1 | Sampled SDA level as driven by the host |
| sda_o | output | 1 | Last stored SDA level, including levels forced by the slave |
| ld_valid | input | 1 | Preload strobe for the contents array |
| ld_addr | input | 8 | Preload address |
| ld_data | input | 8 | Preload data |

## Verification
The bench checks acknowledge timing exactly. A slave that counted the command bits wrongly would pull SDA low one clock early, and a bad edge or a STOP inside a transfer shifts or breaks that timing. Reads are checked against the byte latched by the previous access and not the address being sent. A design that read the array directly, or reversed the bit order, would return the wrong pattern. A repeated START is sent after part of a control byte, so a slave that kept the stale count would acknowledge too early. Pseudo-START levels held without a strobe must leave the readback untouched.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_STOP,
    EV_RISE_OK,
    EV_RISE_BAD
  } line_ev_e;
endpackage

// File: rtl/i2cs_line_decode.sv
module i2cs_line_decode
  import i2cs_pkg::*;
(
  input  logic     scl_q,
  input  logic     sda_q,
  input  logic     scl_n,
  input  logic     sda_n,
  output line_ev_e ev
);
  always_comb begin
    if (scl_q && scl_n && (sda_q != sda_n)) ev = sda_n ? EV_STOP : EV_START;
    else if (!scl_q && scl_n)               ev = (sda_q == sda_n) ? EV_RISE_OK : EV_RISE_BAD;
    else                                    ev = EV_NONE;
  end
endmodule

// File: rtl/i2cs_store.sv
module i2cs_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // R10: preload lands at its address
  p_preload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          smp_scl,
  input  logic          smp_sda,
  input  line_ev_e      ev,
  output logic          scl_q,
  output logic          sda_q,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int CMD_END  = CW + 1;
  localparam int ADDR_END = CW + 1 + AW;
  localparam int TW       = $clog2(ADDR_END + 1);
  localparam logic [TW-1:0] T_ONE  = TW'(1);
  localparam logic [TW-1:0] T_CMD  = TW'(CMD_END);
  localparam logic [TW-1:0] T_ADDR = TW'(ADDR_END);

  logic [TW-1:0] tick_q, tick_n;
  logic [CW-1:0] cmd_q, cmd_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic          ack_q, ack_n;
  logic          sda_eff;
  logic          idle;

  assign idle    = (tick_q == '0) && !ack_q;
  assign rd_addr = {addr_q[AW-2:0], smp_sda};

  always_comb begin
    tick_n  = tick_q;
    cmd_n   = cmd_q;
    addr_n  = addr_q;
    data_n  = data_q;
    ack_n   = ack_q;
    sda_eff = smp_sda;
    if (smp_valid) begin
      if (ev == EV_START) begin
        tick_n = T_ONE;
        cmd_n  = '0;
      end else if (!idle && (ev == EV_RISE_OK || ev == EV_RISE_BAD)) begin
        if (ack_q) begin
          sda_eff = 1'b0;
          ack_n   = 1'b0;
        end else if (ev == EV_RISE_OK) begin
          if (tick_q < T_CMD) begin
            cmd_n  = {cmd_q[CW-2:0], smp_sda};
            tick_n = tick_q + T_ONE;
            if (tick_n == T_CMD) ack_n = 1'b1;
          end else if (tick_q < T_ADDR) begin
            if (cmd_q[0]) sda_eff = data_q[DW-1];
            addr_n = {addr_q[AW-2:0], smp_sda};
            data_n = {data_q[DW-2:0], 1'b0};
            tick_n = tick_q + T_ONE;
            if (tick_n == T_ADDR) begin
              data_n = rd_data;
              ack_n  = 1'b1;
              tick_n = '0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      ack_q  <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      tick_q <= tick_n;
      cmd_q  <= cmd_n;
      addr_q <= addr_n;
      data_q <= data_n;
      ack_q  <= ack_n;
      if (smp_valid) begin
        scl_q <= smp_scl;
        sda_q <= sda_eff;
      end
    end
  end

  // R2: START restarts the count and clears the control byte
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ev == EV_START) |=> (tick_q == T_ONE && cmd_q == '0));
  // R3: idle ignores everything but START
  p_idle_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && idle && ev != EV_START) |=>
      ($stable(tick_q) && $stable(cmd_q) && $stable(addr_q) && $stable(data_q) && !ack_q));
  // R4: a pending acknowledge forces SDA low on the rising edge
  p_ack_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ack_q && (ev == EV_RISE_OK || ev == EV_RISE_BAD)) |=> (!sda_q && !ack_q));
  // R8: a rising edge with SDA moving is not a bit
  p_bad_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !ack_q && ev == EV_RISE_BAD) |=>
      ($stable(tick_q) && $stable(cmd_q) && $stable(addr_q)));
  // R9: STOP touches only the stored levels
  p_stop_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ev == EV_STOP) |=>
      ($stable(tick_q) && $stable(cmd_q) && $stable(addr_q) && $stable(data_q) && $stable(ack_q)));
  // R12: no strobe, no change
  p_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(sda_q) && $stable(scl_q) && $stable(tick_q)));
endmodule

// File: rtl/i2c_sample_eeprom.sv
module i2c_sample_eeprom
  import i2cs_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          smp_scl,
  input  logic          smp_sda,
  output logic          sda_o,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data
);
  line_ev_e      ev;
  logic          scl_q, sda_q;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  i2cs_line_decode u_dec (
    .scl_q (scl_q),
    .sda_q (sda_q),
    .scl_n (smp_scl),
    .sda_n (smp_sda),
    .ev    (ev)
  );

  i2cs_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_scl   (smp_scl),
    .smp_sda   (smp_sda),
    .ev        (ev),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  i2cs_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_valid),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign sda_o = sda_q;
endmodule

// File: tb/i2c_sample_eeprom_tb.sv
module i2c_sample_eeprom_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0, smp_scl = 1'b1, smp_sda = 1'b1;
  logic       ld_valid = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  logic       sda_o;

  int n_cmp = 0, n_bad = 0;
  logic   q_exp[$];
  string  q_tag[$];
  logic   seen = 1'b0;
  logic [7:0] model [256];
  logic [7:0] latched = 8'h00;

  always #5 clk = ~clk;

  i2c_sample_eeprom u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_scl(smp_scl),
    .smp_sda(smp_sda), .sda_o(sda_o), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  // monitor: compare readback one edge after each accepted sample
  always @(posedge clk) seen <= smp_valid;
  always @(negedge clk) begin
    if (seen) begin
      logic e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_cmp++;
      if (sda_o !== e) begin
        n_bad++;
        $display("FAIL %s: sda_o=%b expected %b", t, sda_o, e);
      end
    end
  end

  task automatic smp(input logic c, input logic d, input logic e, input string t);
    @(negedge clk);
    smp_valid = 1'b1; smp_scl = c; smp_sda = d;
    q_exp.push_back(e); q_tag.push_back(t);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic bit_clk(input logic b, input logic e_rise, input string t);
    smp(1'b0, b, b, t);
    smp(1'b1, b, e_rise, t);
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
    model[a] = d;
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] addr, input bit viol,
                      input int stop_at, input string ack_tag, input string dat_tag);
    smp(1'b1, 1'b0, 1'b0, "R2");
    smp(1'b0, 1'b0, 1'b0, "R2");
    for (int i = 7; i >= 0; i--) begin
      bit_clk(cmd[i], cmd[i], "R2");
      if (viol && i == 4) begin
        smp(1'b0, 1'b0, 1'b0, "R8");
        smp(1'b1, 1'b1, 1'b1, "R8");
      end
    end
    bit_clk(1'b1, 1'b0, ack_tag);
    for (int i = 7; i >= 0; i--) begin
      bit_clk(addr[i], cmd[0] ? latched[i] : addr[i], dat_tag);
      if (i == stop_at) smp(1'b1, 1'b1, 1'b1, "R9");
    end
    bit_clk(1'b1, 1'b0, "R6");
    latched = model[addr];
    smp(1'b1, 1'b1, 1'b1, "R9");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (sda_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: sda_o=%b expected 1", sda_o);
    end

    load(8'h3C, 8'hA5);
    load(8'h81, 8'h5A);
    load(8'hFF, 8'hC3);
    load(8'h00, 8'h7E);

    // R3: clocks while idle never get acknowledged
    bit_clk(1'b1, 1'b1, "R3"); bit_clk(1'b0, 1'b0, "R3");
    for (int i = 0; i < 7; i++) bit_clk(1'b1, 1'b1, "R3");
    bit_clk(1'b1, 1'b1, "R3");

    xfer(8'hA0, 8'h3C, 1'b0, -1, "R4", "R7");   // write, latches A5
    xfer(8'hA1, 8'h81, 1'b0, -1, "R4", "R5");   // read returns A5
    xfer(8'hA1, 8'hFF, 1'b1, -1, "R8", "R5");   // bad edge, returns 5A
    xfer(8'hA0, 8'h00, 1'b0, 4,  "R4", "R7");   // STOP inside address phase

    // R11: partial control byte, then repeated START
    smp(1'b1, 1'b0, 1'b0, "R11");
    smp(1'b0, 1'b0, 1'b0, "R11");
    bit_clk(1'b1, 1'b1, "R11"); bit_clk(1'b0, 1'b0, "R11"); bit_clk(1'b1, 1'b1, "R11");
    xfer(8'hA1, 8'h3C, 1'b0, -1, "R11", "R9");  // returns 7E latched after STOP run

    load(8'h3C, 8'h99);
    xfer(8'hA1, 8'h3C, 1'b0, -1, "R4", "R5");   // returns A5, latches 99
    xfer(8'hA1, 8'h00, 1'b0, -1, "R4", "R10");  // returns preloaded 99

    // R12: START-like levels without a strobe
    @(negedge clk);
    smp_scl = 1'b1; smp_sda = 1'b0;
    repeat (10) @(negedge clk);
    n_cmp++;
    if (sda_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R12: sda_o=%b expected 1", sda_o);
    end
    smp_sda = 1'b1;
    xfer(8'hA0, 8'h81, 1'b0, -1, "R12", "R7");

    repeat (4) @(negedge clk);
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", q_exp.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule